// File: doc/BRIEF.md
# Floating-Point Condition Code and Predicate Unit

This block keeps the four floating-point condition flags of a processor: negative (N), zero (Z), infinity (I) and unordered (NAN). After an arithmetic or move result it rewrites all four flags from the result's sign and class alone. After a compare it rewrites them from the relation between the operands. A direct load port writes any 4-bit value into the flags.

A predicate request names one of 32 conditional tests with a 6-bit selector. The unit evaluates that test against the flags as they stand in the request cycle. One cycle later it presents a registered true/false decision with a one-cycle valid pulse. Tests whose selector bit 4 is set are signaling tests. Evaluating one of them while NAN is set raises the branch-on-unordered (BSUN) flag. That flag stays set until it is cleared on purpose.

The unordered flag means that greater, equal and less no longer cover every case. A test and its "not" form are exact complements. A test and its apparent opposite both fail when the operands are unordered.

Two small state machines carry the behaviour:
- The flag-source selector in `fpcc_code_reg` picks one of four sources each cycle: SRC_HOLD, SRC_RESULT, SRC_COMPARE or SRC_LOAD. Load has priority over compare, and compare has priority over result.
- The BSUN machine in `fpcc_flag_fsm` has two states, BS_CLEAR and BS_RAISED.
  - BS_CLEAR → BS_RAISED when a signaling test is requested while NAN=1.
  - BS_RAISED → BS_CLEAR when the clear input is high and no raise happens in the same cycle.
  - In every other case the machine stays in its current state.

Top module: `fp_ccode_unit`

## Requirements
- R1: After reset, `codes` is 0000, `cond_out` is 0, `cond_valid` is 0 and `bsun_flag` is 0.
- R2: When `res_upd` is high and no higher-priority source is active, `codes` (bit 3=N, bit 2=Z, bit 1=I, bit 0=NAN) takes these values from the next cycle on:
  - N is `res_sign`.
  - Z is 1 for class 01 (zero).
  - I is 1 for class 10 (infinity).
  - NAN is 1 for class 11 (NaN).
  - Class 00 (finite nonzero) sets none of Z, I or NAN.
- R3: When `cmp_upd` is high and `load_en` is low, `cmp_rel` sets `codes` on the next cycle as follows:
  - 00 (greater) gives 0000.
  - 01 (less) gives 1000.
  - 10 (equal) gives 0100.
  - 11 (unordered) gives 0001, so an unordered compare always sets NAN.
- R4: When `load_en` is high, `load_codes` is copied into `codes` on the next cycle, whatever the other strobes do. When both `cmp_upd` and `res_upd` are high, the compare wins.
- R5: While none of `res_upd`, `cmp_upd` or `load_en` is high, `codes` does not change.
- R6: One cycle after `pred_req`, `cond_out` holds the selected test and `cond_valid` is high for that one cycle. The test is evaluated on the flags as they were in the request cycle, even if an update lands on the same edge. Equations by `pred_sel[3:0]`:
  - 0: false
  - 1: Z
  - 2: !(NAN|Z|N)
  - 3: Z|!(NAN|N)
  - 4: N&!(NAN|Z)
  - 5: Z|(N&!NAN)
  - 6: !(NAN|Z)
  - 7: !NAN
  - 8: NAN
  - 9: NAN|Z
  - 10: NAN|!(N|Z)
  - 11: NAN|Z|!N
  - 12: NAN|(N&!Z)
  - 13: NAN|Z|N
  - 14: !Z
  - 15: true
- R7: `pred_sel[4]` does not change the equation, and `pred_sel[5]` has no effect on `cond_out` or `bsun_flag`.
- R8: A request with `pred_sel[4]`=1 while NAN=1 sets `bsun_flag` on the next cycle. A request with `pred_sel[4]`=0 never sets it, and this includes equal (000001) and not-equal (001110).
- R9: `bsun_flag` stays set until a cycle with `bsun_clr` high, which clears it on the next cycle. When a raise and a clear fall in the same cycle, the raise wins.
- R10: Flag values outside the eight encodings a result can produce (for example Z and I both set) are evaluated by the raw equations of R6, without any correction.
- R11: With NAN=1, greater-than (010010) and less-or-equal (010101) both give false and set BSUN, while not-greater-than (011101) gives true.
- R12: While `pred_req` stays low, `cond_out` keeps its last value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| res_upd | input | 1 | Update flags from a result's class |
| res_sign | input | 1 | Sign of the result |
| res_class | input | 2 | 00 finite nonzero, 01 zero, 10 infinity, 11 NaN |
| cmp_upd | input | 1 | Update flags from a compare |
| cmp_rel | input | 2 | 00 greater, 01 less, 10 equal, 11 unordered |
| load_en | input | 1 | Write `load_codes` directly |
| load_codes | input | 4 | Raw flag value {N,Z,I,NAN} |
| pred_req | input | 1 | Evaluate the predicate named by `pred_sel` |
| pred_sel | input | 6 | Predicate selector |
| bsun_clr | input | 1 | Clear the sticky BSUN flag |
| cond_out | output | 1 | Registered predicate result |
| cond_valid | output | 1 | One-cycle pulse marking a fresh `cond_out` |
| bsun_flag | output | 1 | Sticky branch-on-unordered flag |
| codes | output | 4 | Current flags {N,Z,I,NAN} |

## Verification
Two pairs of functions can act in the same cycle here. The first pair is a predicate request and a flag update, and the second is a signaling raise and a BSUN clear. The bench provokes the first by issuing a request together with a result strobe that changes NAN. It judges the decision against the flags that held before the update, and judges the flags afterwards against the update alone. It provokes the second by asserting `bsun_clr` in the same cycle as a signaling request with NAN set, and expects the flag to remain set. A clear on its own, with no request, must then drop the flag.

// File: rtl/fpcc_pkg.sv
package fpcc_pkg;

    localparam int CC_W    = 4;
    localparam int PSEL_W  = 6;
    localparam int EQSEL_W = 4;
    localparam int SIG_BIT = 4;

    typedef enum logic [1:0] {
        CLS_FINITE = 2'b00,
        CLS_ZERO   = 2'b01,
        CLS_INF    = 2'b10,
        CLS_NAN    = 2'b11
    } rclass_e;

    typedef enum logic [1:0] {
        REL_GT = 2'b00,
        REL_LT = 2'b01,
        REL_EQ = 2'b10,
        REL_UN = 2'b11
    } crel_e;

    typedef struct packed {
        logic n;
        logic z;
        logic i;
        logic nan;
    } ccode_t;

    typedef enum logic [1:0] {
        SRC_HOLD    = 2'b00,
        SRC_RESULT  = 2'b01,
        SRC_COMPARE = 2'b10,
        SRC_LOAD    = 2'b11
    } src_e;

    typedef enum logic {
        BS_CLEAR  = 1'b0,
        BS_RAISED = 1'b1
    } bsun_st_e;

endpackage

// File: rtl/fpcc_code_reg.sv
module fpcc_code_reg
    import fpcc_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    res_upd,
    input  logic    res_sign,
    input  rclass_e res_cls,
    input  logic    cmp_upd,
    input  crel_e   cmp_rel,
    input  logic    load_en,
    input  ccode_t  load_val,
    output ccode_t  cc_q
);

    src_e   src;
    ccode_t from_res;
    ccode_t from_cmp;
    ccode_t cc_d;

    // Source selection: load, then compare, then result.
    always_comb begin
        if (load_en)      src = SRC_LOAD;
        else if (cmp_upd) src = SRC_COMPARE;
        else if (res_upd) src = SRC_RESULT;
        else              src = SRC_HOLD;
    end

    always_comb begin
        from_res.n   = res_sign;
        from_res.z   = (res_cls == CLS_ZERO);
        from_res.i   = (res_cls == CLS_INF);
        from_res.nan = (res_cls == CLS_NAN);
    end

    always_comb begin
        from_cmp = '0;
        unique case (cmp_rel)
            REL_GT: from_cmp = '0;
            REL_LT: from_cmp.n   = 1'b1;
            REL_EQ: from_cmp.z   = 1'b1;
            REL_UN: from_cmp.nan = 1'b1;
        endcase
    end

    always_comb begin
        unique case (src)
            SRC_HOLD:    cc_d = cc_q;
            SRC_RESULT:  cc_d = from_res;
            SRC_COMPARE: cc_d = from_cmp;
            SRC_LOAD:    cc_d = load_val;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cc_q <= '0;
        else        cc_q <= cc_d;
    end

endmodule

// File: rtl/fpcc_pred_eval.sv
module fpcc_pred_eval
    import fpcc_pkg::*;
(
    input  ccode_t               cc,
    input  logic [EQSEL_W-1:0]   eq_sel,
    output logic                 hit
);

    logic n, z, u;

    // The I flag takes part in no equation.
    logic cc_i_unused;
    assign cc_i_unused = cc.i;

    assign n = cc.n;
    assign z = cc.z;
    assign u = cc.nan;

    always_comb begin
        unique case (eq_sel)
            4'd0:  hit = 1'b0;
            4'd1:  hit = z;
            4'd2:  hit = ~(u | z | n);
            4'd3:  hit = z | ~(u | n);
            4'd4:  hit = n & ~(u | z);
            4'd5:  hit = z | (n & ~u);
            4'd6:  hit = ~(u | z);
            4'd7:  hit = ~u;
            4'd8:  hit = u;
            4'd9:  hit = u | z;
            4'd10: hit = u | ~(n | z);
            4'd11: hit = u | z | ~n;
            4'd12: hit = u | (n & ~z);
            4'd13: hit = u | z | n;
            4'd14: hit = ~z;
            4'd15: hit = 1'b1;
        endcase
    end

endmodule

// File: rtl/fpcc_flag_fsm.sv
module fpcc_flag_fsm
    import fpcc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic req,
    input  logic signaling,
    input  logic nan_now,
    input  logic hit,
    input  logic clr,
    output logic cond_q,
    output logic valid_q,
    output logic bsun_q
);

    bsun_st_e state, state_nx;
    logic     raise;

    assign raise = req & signaling & nan_now;

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= BS_CLEAR;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            BS_CLEAR:  if (raise)        state_nx = BS_RAISED;
            BS_RAISED: if (clr && !raise) state_nx = BS_CLEAR;
        endcase
    end

    assign bsun_q = (state == BS_RAISED);

    // Registered decision outputs.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cond_q  <= 1'b0;
            valid_q <= 1'b0;
        end else begin
            valid_q <= req;
            if (req) cond_q <= hit;
        end
    end

endmodule

// File: rtl/fp_ccode_unit.sv
module fp_ccode_unit
    import fpcc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              res_upd,
    input  logic              res_sign,
    input  logic [1:0]        res_class,
    input  logic              cmp_upd,
    input  logic [1:0]        cmp_rel,
    input  logic              load_en,
    input  logic [CC_W-1:0]   load_codes,
    input  logic              pred_req,
    input  logic [PSEL_W-1:0] pred_sel,
    input  logic              bsun_clr,
    output logic              cond_out,
    output logic              cond_valid,
    output logic              bsun_flag,
    output logic [CC_W-1:0]   codes
);

    ccode_t cc_cur;
    logic   hit;
    logic   sel_hi_unused;

    assign sel_hi_unused = pred_sel[PSEL_W-1];

    fpcc_code_reg u_code (
        .clk      (clk),
        .rst_n    (rst_n),
        .res_upd  (res_upd),
        .res_sign (res_sign),
        .res_cls  (rclass_e'(res_class)),
        .cmp_upd  (cmp_upd),
        .cmp_rel  (crel_e'(cmp_rel)),
        .load_en  (load_en),
        .load_val (ccode_t'(load_codes)),
        .cc_q     (cc_cur)
    );

    fpcc_pred_eval u_eval (
        .cc     (cc_cur),
        .eq_sel (pred_sel[EQSEL_W-1:0]),
        .hit    (hit)
    );

    fpcc_flag_fsm u_flag (
        .clk       (clk),
        .rst_n     (rst_n),
        .req       (pred_req),
        .signaling (pred_sel[SIG_BIT]),
        .nan_now   (cc_cur.nan),
        .hit       (hit),
        .clr       (bsun_clr),
        .cond_q    (cond_out),
        .valid_q   (cond_valid),
        .bsun_q    (bsun_flag)
    );

    assign codes = cc_cur;

endmodule

// File: rtl/fpcc_checker.sv
module fpcc_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       res_upd,
    input logic       cmp_upd,
    input logic [1:0] cmp_rel,
    input logic       load_en,
    input logic [3:0] load_codes,
    input logic       pred_req,
    input logic [5:0] pred_sel,
    input logic       bsun_clr,
    input logic       cond_out,
    input logic       cond_valid,
    input logic       bsun_flag,
    input logic [3:0] codes
);

    p_load_copy_r4: assert property (@(posedge clk) disable iff (!rst_n)
        load_en |=> codes == $past(load_codes));

    p_unord_nan_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_upd && !load_en && cmp_rel == 2'b11) |=> codes == 4'b0001);

    p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!res_upd && !cmp_upd && !load_en) |=> $stable(codes));

    p_valid_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        pred_req |=> cond_valid);

    p_no_valid_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !pred_req |=> !cond_valid);

    p_signal_raise_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (pred_req && pred_sel[4] && codes[0]) |=> bsun_flag);

    p_quiet_no_raise_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!bsun_flag && !(pred_req && pred_sel[4])) |=> !bsun_flag);

    p_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (bsun_flag && !bsun_clr) |=> bsun_flag);

    p_cond_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !pred_req |=> $stable(cond_out));

endmodule

bind fp_ccode_unit fpcc_checker u_fpcc_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .res_upd    (res_upd),
    .cmp_upd    (cmp_upd),
    .cmp_rel    (cmp_rel),
    .load_en    (load_en),
    .load_codes (load_codes),
    .pred_req   (pred_req),
    .pred_sel   (pred_sel),
    .bsun_clr   (bsun_clr),
    .cond_out   (cond_out),
    .cond_valid (cond_valid),
    .bsun_flag  (bsun_flag),
    .codes      (codes)
);

// File: tb/tb_fp_ccode_unit.sv
module tb_fp_ccode_unit;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       res_upd = 1'b0, res_sign = 1'b0, cmp_upd = 1'b0, load_en = 1'b0;
    logic [1:0] res_class = '0, cmp_rel = '0;
    logic [3:0] load_codes = '0;
    logic       pred_req = 1'b0, bsun_clr = 1'b0;
    logic [5:0] pred_sel = '0;
    logic       cond_out, cond_valid, bsun_flag;
    logic [3:0] codes;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    typedef struct {
        logic       c;
        logic       b;
        logic [5:0] sel;
        logic [3:0] cc;
    } exp_t;

    exp_t       sb[$];
    logic [3:0] m_cc = 4'b0000;
    logic       m_bsun = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    fp_ccode_unit dut (
        .clk(clk), .rst_n(rst_n), .res_upd(res_upd), .res_sign(res_sign),
        .res_class(res_class), .cmp_upd(cmp_upd), .cmp_rel(cmp_rel),
        .load_en(load_en), .load_codes(load_codes), .pred_req(pred_req),
        .pred_sel(pred_sel), .bsun_clr(bsun_clr), .cond_out(cond_out),
        .cond_valid(cond_valid), .bsun_flag(bsun_flag), .codes(codes)
    );

    // Predicate truth from the equations listed in R6.
    function automatic logic pexp(input logic [3:0] s, input logic [3:0] c);
        logic n, z, u;
        n = c[3]; z = c[2]; u = c[0];
        case (s)
            4'd0:  return 1'b0;
            4'd1:  return z;
            4'd2:  return !(u || z || n);
            4'd3:  return z || !(u || n);
            4'd4:  return n && !(u || z);
            4'd5:  return z || (n && !u);
            4'd6:  return !(u || z);
            4'd7:  return !u;
            4'd8:  return u;
            4'd9:  return u || z;
            4'd10: return u || !(n || z);
            4'd11: return u || z || !n;
            4'd12: return u || (n && !z);
            4'd13: return u || z || n;
            4'd14: return !z;
            default: return 1'b1;
        endcase
    endfunction

    task automatic check(input string tag, input logic [3:0] got, input logic [3:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got=%b exp=%b", tag, got, exp);
        end
    endtask

    // Driver: one cycle of stimulus, expected items into the scoreboard.
    task automatic drive(input logic ru, input logic sg, input logic [1:0] cl,
                         input logic cu, input logic [1:0] rl,
                         input logic ld, input logic [3:0] lc,
                         input logic pr, input logic [5:0] ps, input logic clr);
        exp_t e;
        logic raise;
        res_upd = ru; res_sign = sg; res_class = cl;
        cmp_upd = cu; cmp_rel = rl; load_en = ld; load_codes = lc;
        pred_req = pr; pred_sel = ps; bsun_clr = clr;
        raise = pr && ps[4] && m_cc[0];
        m_bsun = raise || (m_bsun && !clr);
        if (pr) begin
            e.c = pexp(ps[3:0], m_cc); e.b = m_bsun; e.sel = ps; e.cc = m_cc;
            sb.push_back(e);
        end
        if (ld)      m_cc = lc;
        else if (cu) m_cc = (rl == 2'b00) ? 4'b0000 : (rl == 2'b01) ? 4'b1000 :
                            (rl == 2'b10) ? 4'b0100 : 4'b0001;
        else if (ru) m_cc = {sg, cl == 2'b01, cl == 2'b10, cl == 2'b11};
        @(negedge clk);
        res_upd = 0; cmp_upd = 0; load_en = 0; pred_req = 0; bsun_clr = 0;
    endtask

    task automatic idle(); drive(0,0,2'b00,0,2'b00,0,4'h0,0,6'h00,0); endtask
    task automatic load(input logic [3:0] v); drive(0,0,2'b00,0,2'b00,1,v,0,6'h00,0); endtask
    task automatic pred(input logic [5:0] s); drive(0,0,2'b00,0,2'b00,0,4'h0,1,s,0); endtask

    // Monitor: pops expected decisions when the design marks one valid.
    always @(negedge clk) begin
        if (rst_n && cond_valid) begin
            if (sb.size() == 0) begin
                checks++; errors++;
                $display("FAIL R6 unexpected cond_valid got=1 exp=0");
            end else begin
                exp_t e;
                e = sb.pop_front();
                checks++;
                if (cond_out !== e.c) begin
                    errors++;
                    $display("FAIL R6/R7/R10 sel=%b codes=%b cond got=%b exp=%b",
                             e.sel, e.cc, cond_out, e.c);
                end
                checks++;
                if (bsun_flag !== e.b) begin
                    errors++;
                    $display("FAIL R8/R9 sel=%b codes=%b bsun got=%b exp=%b",
                             e.sel, e.cc, bsun_flag, e.b);
                end
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog got=timeout exp=finish");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic last;
        repeat (3) @(negedge clk);
        // R1: reset values
        check("R1 codes", codes, 4'b0000);
        check("R1 cond/valid/bsun", {1'b0, cond_out, cond_valid, bsun_flag}, 4'b0000);
        rst_n = 1'b1;
        @(negedge clk);

        // R2: result classes with both signs
        for (int s = 0; s < 2; s++)
            for (int c = 0; c < 4; c++) begin
                drive(1, s[0], c[1:0], 0, 2'b00, 0, 4'h0, 0, 6'h00, 0);
                check("R2 result class", codes, m_cc);
            end

        // R3: compare outcomes
        for (int r = 0; r < 4; r++) begin
            drive(0, 0, 2'b00, 1, r[1:0], 0, 4'h0, 0, 6'h00, 0);
            check("R3 compare", codes, m_cc);
        end
        check("R3 unordered sets NAN", codes, 4'b0001);

        // R5: idle cycles keep the codes
        idle(); idle(); idle();
        check("R5 hold", codes, 4'b0001);

        // R4: priorities
        drive(1, 1, 2'b10, 1, 2'b10, 1, 4'b0110, 0, 6'h00, 0);
        check("R4 load wins", codes, 4'b0110);
        drive(1, 1, 2'b10, 1, 2'b01, 0, 4'h0, 0, 6'h00, 0);
        check("R4 compare beats result", codes, 4'b1000);

        // R6/R7/R8/R10: every code value against every selector
        for (int v = 0; v < 16; v++) begin
            load(v[3:0]);
            check("R4 raw load", codes, v[3:0]);
            for (int s = 0; s < 64; s++) begin
                pred(s[5:0]);
                if (m_bsun) drive(0,0,2'b00,0,2'b00,0,4'h0,0,6'h00,1);
            end
        end

        // R11: unordered breaks trichotomy
        load(4'b0001);
        pred(6'b010010);
        pred(6'b010101);
        pred(6'b011101);
        idle();
        check("R11 bsun after signaling tests", {3'b0, bsun_flag}, 4'b0001);

        // R9: sticky and clear
        idle(); idle();
        check("R9 sticky", {3'b0, bsun_flag}, 4'b0001);
        drive(0, 0, 2'b00, 0, 2'b00, 0, 4'h0, 0, 6'h00, 1);
        check("R9 clear", {3'b0, bsun_flag}, 4'b0000);
        drive(0, 0, 2'b00, 0, 2'b00, 0, 4'h0, 1, 6'b010001, 1);
        idle();
        check("R9 raise beats clear", {3'b0, bsun_flag}, 4'b0001);
        drive(0, 0, 2'b00, 0, 2'b00, 0, 4'h0, 0, 6'h00, 1);

        // R8: quiet equal / not-equal with NAN set
        pred(6'b000001);
        pred(6'b001110);
        idle();
        check("R8 quiet no bsun", {3'b0, bsun_flag}, 4'b0000);

        // R6: predicate and update in the same cycle use the old codes
        load(4'b0001);
        drive(1, 0, 2'b00, 0, 2'b00, 0, 4'h0, 1, 6'b010010, 0);
        check("R6 update alongside request", codes, 4'b0000);
        drive(1, 0, 2'b11, 0, 2'b00, 0, 4'h0, 1, 6'b000111, 0);
        check("R6 update to NaN alongside request", codes, 4'b0001);

        // R12: cond_out holds without requests
        idle();
        last = cond_out;
        idle(); idle();
        check("R12 cond hold", {3'b0, cond_out}, {3'b0, last});
        check("R12 scoreboard drained", 4'(sb.size()), 4'd0);

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule